// File: doc/BRIEF.md
# Per-CPU Highest-Priority Pending Resolver

This block sits beside an interrupt distributor and, for every CPU interface, picks the most urgent interrupt that is both enabled and pending for that CPU. It then decides two separate things. First, whether that interrupt passes the CPU's priority mask and so shows up as the highest pending ID that software can read. Second, whether it also beats the priority of the interrupt the CPU is already running, which is the condition for raising that CPU's request line.

All state that sets the inputs lives outside the block: the enable and pending bits, the priority tables, the mask and the running priority. This includes acknowledge and end-of-interrupt handling. The upstream registers are expected to come out of reset with a mask of 0xF0 and a running priority of 0x100, which means idle.

Every input is sampled on each clock. The results are registered, so they appear one cycle later. No input or output carries a data stream, so every pin is a plain level with no valid/ready handshake. The parameters must satisfy NUM_IRQ > BANKED_IRQS.

Top module: `pend_resolver`

## Requirements
- R1: An interrupt is a candidate for CPU c only when its enable bit and its pending bit at position c*NUM_IRQ+id are both 1.
- R2: Among the candidates, the one with the numerically smallest priority wins. When several candidates share that priority, the lowest interrupt ID wins.
- R3: When no candidate exists, the highest-pending ID for that CPU is 1023 and its request line is 0.
- R4: The winner is reported as the highest-pending ID only if its priority is less than or equal to that CPU's 8-bit mask. Otherwise the ID is 1023 and the request line is 0.
- R5: A CPU's request line is 1 only when the reported winner's priority is strictly less than that CPU's 9-bit running priority. A running priority of 0x100 is idle and is beaten by any priority.
- R6: When the global enable is 0, or the enable of a CPU interface is 0, that CPU's request line is 0 and its ID is 1023.
- R7: IDs below 32 take their priority from the bank of the CPU being resolved, at prio_banked[(c*32+id)*8 +: 8]. IDs of 32 and above use the shared table at prio_shared[(id-32)*8 +: 8].
- R8: The outputs reflect the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R9: While reset is asserted, every request line is 0 and every ID is 1023.
- R10: The result for one CPU depends only on that CPU's enable, pending, bank, mask, running priority and enable, together with the shared table and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dist_en | input | 1 | Global enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| irq_enable | input | NUM_CPU*NUM_IRQ | Enable bit per CPU and ID, at c*NUM_IRQ+id |
| irq_pending | input | NUM_CPU*NUM_IRQ | Pending bit per CPU and ID, at c*NUM_IRQ+id |
| prio_banked | input | NUM_CPU*BANKED_IRQS*8 | Per-CPU priorities for the low IDs |
| prio_shared | input | (NUM_IRQ-BANKED_IRQS)*8 | Shared priorities for the remaining IDs |
| prio_mask | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority (0x100 = idle) |
| cpu_irq | output | NUM_CPU | Registered request line per CPU |
| hp_id | output | NUM_CPU*10 | Registered highest-pending ID per CPU (1023 = none) |

## Verification
The resolver is driven with several patterns, and each one isolates a different part of its behaviour:
- Empty and half-qualified sets, where only the enable bit or only the pending bit is set, or the bit is set for the other CPU. These show that a candidate needs both bits at its own position.
- Equal-priority sets. These show the lowest-ID tie rule, which a non-strict comparison would break.
- A banked ID placed against a shared ID, with different bank values per CPU. This separates the banked table from the shared one and shows that the two CPUs resolve independently.
- Priorities set exactly at the mask, and exactly at the running priority, and one step either side. These pin down the inclusive mask test and the strict running-priority test.

Long random runs with mixed enables complete the coverage. Each cycle is also checked just before the edge, which exposes any path that skips the output register.

// File: rtl/pres_pkg.sv
package pres_pkg;
  parameter int ID_W = 10;
  parameter int PRIO_W = 8;
  parameter logic [ID_W-1:0] NONE_ID = 10'd1023;
  parameter logic [PRIO_W:0] IDLE_PRIO = 9'h100;
  typedef logic [PRIO_W:0] xprio_t;
  typedef logic [ID_W-1:0] irq_id_t;
endpackage

// File: rtl/prio_gather.sv
module prio_gather #(
  parameter int NUM_IRQ = 64,
  parameter int BANKED_IRQS = 32,
  localparam int SHARED = NUM_IRQ - BANKED_IRQS
) (
  input  logic [BANKED_IRQS*8-1:0] bank_row,
  input  logic [SHARED*8-1:0]      shared_row,
  output logic [NUM_IRQ*8-1:0]     prio_vec
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    if (i < BANKED_IRQS) begin : g_bank
      assign prio_vec[i*8 +: 8] = bank_row[i*8 +: 8];
    end else begin : g_shr
      assign prio_vec[i*8 +: 8] = shared_row[(i-BANKED_IRQS)*8 +: 8];
    end
  end
endmodule

// File: rtl/best_scan.sv
module best_scan
  import pres_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   cand,
  input  logic [NUM_IRQ*8-1:0] prio_vec,
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx,
  output xprio_t               win_prio
);
  always_comb begin
    win_prio = IDLE_PRIO;
    win_idx  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && ({1'b0, prio_vec[i*8 +: 8]} < win_prio)) begin
        win_prio = {1'b0, prio_vec[i*8 +: 8]};
        win_idx  = IDX_W'(i);
      end
    end
    found = (win_prio != IDLE_PRIO);
  end

  assert_winner_is_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[win_idx]);
endmodule

// File: rtl/req_gate.sv
module req_gate
  import pres_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dist_en,
  input  logic             cpu_en,
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  xprio_t           win_prio,
  input  logic [7:0]       mask,
  input  xprio_t           run_prio,
  output logic             irq_q,
  output irq_id_t          id_q
);
  logic   report, raise;
  xprio_t prio_q;

  always_comb begin
    report = dist_en && cpu_en && found && (win_prio <= {1'b0, mask});
    raise  = report && (win_prio < run_prio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      id_q   <= NONE_ID;
      prio_q <= IDLE_PRIO;
    end else begin
      irq_q  <= raise;
      id_q   <= report ? ID_W'(win_idx) : NONE_ID;
      prio_q <= report ? win_prio : IDLE_PRIO;
    end
  end

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q != NONE_ID) |-> (prio_q <= {1'b0, $past(mask)}));
  assert_run_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (prio_q < $past(run_prio)));
  assert_req_has_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (id_q != NONE_ID));
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dist_en || !cpu_en) |=> (!irq_q && id_q == NONE_ID));
endmodule

// File: rtl/pend_resolver.sv
module pend_resolver
  import pres_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int BANKED_IRQS = 32,
  localparam int SHARED = NUM_IRQ - BANKED_IRQS,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dist_en,
  input  logic [NUM_CPU-1:0]             cpu_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]     irq_enable,
  input  logic [NUM_CPU*NUM_IRQ-1:0]     irq_pending,
  input  logic [NUM_CPU*BANKED_IRQS*8-1:0] prio_banked,
  input  logic [SHARED*8-1:0]            prio_shared,
  input  logic [NUM_CPU*8-1:0]           prio_mask,
  input  logic [NUM_CPU*9-1:0]           run_prio,
  output logic [NUM_CPU-1:0]             cpu_irq,
  output logic [NUM_CPU*ID_W-1:0]        hp_id
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ*8-1:0] prio_vec;
    logic [NUM_IRQ-1:0]   cand;
    logic                 found;
    logic [IDX_W-1:0]     win_idx;
    xprio_t               win_prio;
    irq_id_t              id_q;

    assign cand = irq_enable[c*NUM_IRQ +: NUM_IRQ] & irq_pending[c*NUM_IRQ +: NUM_IRQ];

    prio_gather #(.NUM_IRQ(NUM_IRQ), .BANKED_IRQS(BANKED_IRQS)) u_gather (
      .bank_row  (prio_banked[c*BANKED_IRQS*8 +: BANKED_IRQS*8]),
      .shared_row(prio_shared),
      .prio_vec  (prio_vec)
    );

    best_scan #(.NUM_IRQ(NUM_IRQ)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand    (cand),
      .prio_vec(prio_vec),
      .found   (found),
      .win_idx (win_idx),
      .win_prio(win_prio)
    );

    req_gate #(.IDX_W(IDX_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .dist_en (dist_en),
      .cpu_en  (cpu_en[c]),
      .found   (found),
      .win_idx (win_idx),
      .win_prio(win_prio),
      .mask    (prio_mask[c*8 +: 8]),
      .run_prio(run_prio[c*9 +: 9]),
      .irq_q   (cpu_irq[c]),
      .id_q    (id_q)
    );

    assign hp_id[c*ID_W +: ID_W] = id_q;
  end
endmodule

// File: tb/pend_resolver_tb.sv
module pend_resolver_tb;
  localparam int NI = 64, NC = 2, NB = 32;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic dist_en_s;
  logic [NC-1:0] cpu_en_s;
  logic [NC*NI-1:0] en_s, pd_s;
  logic [NC*NB*8-1:0] bp_s;
  logic [(NI-NB)*8-1:0] sp_s;
  logic [NC*8-1:0] mask_s;
  logic [NC*9-1:0] run_s;
  logic [NC-1:0] cpu_irq;
  logic [NC*10-1:0] hp_id;

  pend_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en_s), .cpu_en(cpu_en_s),
    .irq_enable(en_s), .irq_pending(pd_s), .prio_banked(bp_s),
    .prio_shared(sp_s), .prio_mask(mask_s), .run_prio(run_s),
    .cpu_irq(cpu_irq), .hp_id(hp_id)
  );

  bit de;
  bit ce[NC];
  bit en[NC][NI];
  bit pd[NC][NI];
  int bp[NC][NB];
  int sp[NI-NB];
  int mask[NC];
  int run[NC];
  int exp_id[NC], exp_irq[NC], prv_id[NC], prv_irq[NC];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int prio_of(int c, int id);
    return (id < NB) ? bp[c][id] : sp[id-NB];
  endfunction

  function automatic void model(int c, output int id, output int irq);
    int best = 256, bi = 1023;
    id = 1023; irq = 0;
    if (!de || !ce[c]) return;
    for (int i = 0; i < NI; i++)
      if (en[c][i] && pd[c][i] && prio_of(c, i) < best) begin
        best = prio_of(c, i); bi = i;
      end
    if (best <= mask[c]) begin
      id = bi; irq = (best < run[c]) ? 1 : 0;
    end
  endfunction

  task automatic pack();
    dist_en_s = de;
    for (int c = 0; c < NC; c++) begin
      cpu_en_s[c] = ce[c];
      mask_s[c*8 +: 8] = mask[c][7:0];
      run_s[c*9 +: 9] = run[c][8:0];
      for (int i = 0; i < NI; i++) begin
        en_s[c*NI+i] = en[c][i];
        pd_s[c*NI+i] = pd[c][i];
      end
      for (int i = 0; i < NB; i++) bp_s[(c*NB+i)*8 +: 8] = bp[c][i][7:0];
    end
    for (int i = 0; i < NI-NB; i++) sp_s[i*8 +: 8] = sp[i][7:0];
  endtask

  task automatic compare(string tag, int c, int eid, int eirq);
    n_chk++;
    if (int'(hp_id[c*10 +: 10]) != eid || int'(cpu_irq[c]) != eirq) begin
      n_fail++;
      $display("FAIL %s cpu%0d: id=%0d irq=%0d, expected id=%0d irq=%0d",
               tag, c, hp_id[c*10 +: 10], cpu_irq[c], eid, eirq);
    end
  endtask

  // apply current model inputs, check one-cycle hold, then the new result
  task automatic cycle(string tag);
    pack();
    #1;
    for (int c = 0; c < NC; c++) compare("R8 hold", c, prv_id[c], prv_irq[c]);
    for (int c = 0; c < NC; c++) model(c, exp_id[c], exp_irq[c]);
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      compare(tag, c, exp_id[c], exp_irq[c]);
      prv_id[c] = exp_id[c]; prv_irq[c] = exp_irq[c];
    end
  endtask

  task automatic clear_all();
    de = 1;
    for (int c = 0; c < NC; c++) begin
      ce[c] = 1; mask[c] = 'hF0; run[c] = 256;
      for (int i = 0; i < NI; i++) begin en[c][i] = 0; pd[c][i] = 0; end
      for (int i = 0; i < NB; i++) bp[c][i] = 'h80;
    end
    for (int i = 0; i < NI-NB; i++) sp[i] = 'h80;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_all();
    pack();
    for (int c = 0; c < NC; c++) begin prv_id[c] = 1023; prv_irq[c] = 0; end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) compare("R9 reset", c, 1023, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: nothing pending
    for (int c = 0; c < NC; c++) for (int i = 0; i < NI; i++) en[c][i] = 1;
    cycle("R3 empty");

    // R1: enabled-only, pending-only, and other-CPU bit
    clear_all();
    en[0][7] = 1; pd[0][9] = 1; pd[1][7] = 1; en[1][9] = 1;
    cycle("R1 half-qualified");
    pd[0][7] = 1;
    cycle("R1 qualified cpu0 only");

    // R2: ties resolve to lowest ID; strict smaller wins
    clear_all();
    for (int c = 0; c < NC; c++) begin
      en[c][5] = 1; pd[c][5] = 1; en[c][40] = 1; pd[c][40] = 1;
      en[c][50] = 1; pd[c][50] = 1; bp[c][5] = 'h40;
    end
    sp[40-NB] = 'h40; sp[50-NB] = 'h40;
    cycle("R2 tie");
    sp[50-NB] = 'h3F;
    cycle("R2 strictly smaller");

    // R7 and R10: bank per CPU vs shared
    clear_all();
    for (int c = 0; c < NC; c++) begin
      en[c][3] = 1; pd[c][3] = 1; en[c][40] = 1; pd[c][40] = 1;
    end
    bp[0][3] = 'h10; bp[1][3] = 'h90; sp[40-NB] = 'h50;
    cycle("R7 banked vs shared");

    // R4: mask boundary
    clear_all();
    en[0][12] = 1; pd[0][12] = 1; bp[0][12] = 'h60; mask[0] = 'h60;
    cycle("R4 prio equals mask");
    mask[0] = 'h5F;
    cycle("R4 prio above mask");

    // R5: running priority boundary
    mask[0] = 'hF0; run[0] = 'h60;
    cycle("R5 prio equals running");
    run[0] = 'h61;
    cycle("R5 prio below running");
    run[0] = 256;
    cycle("R5 idle running");

    // R6 and R10: global and per-CPU disable
    for (int c = 0; c < NC; c++) begin en[c][33] = 1; pd[c][33] = 1; end
    de = 0;
    cycle("R6 global disable");
    de = 1; ce[1] = 0;
    cycle("R6 cpu1 disabled R10 cpu0 unaffected");
    ce[1] = 1;
    cycle("R10 both enabled");

    // random mix exercising all rules together
    for (int k = 0; k < 3000; k++) begin
      de = ($urandom_range(0, 15) != 0);
      for (int c = 0; c < NC; c++) begin
        ce[c] = ($urandom_range(0, 7) != 0);
        mask[c] = $urandom_range(0, 255);
        run[c] = $urandom_range(0, 256);
        for (int i = 0; i < NI; i++) begin
          en[c][i] = ($urandom_range(0, 3) != 0);
          pd[c][i] = ($urandom_range(0, 5) == 0);
        end
        for (int i = 0; i < NB; i++) bp[c][i] = $urandom_range(0, 15) * 16;
      end
      for (int i = 0; i < NI-NB; i++) sp[i] = $urandom_range(0, 15) * 16;
      cycle("R2 R4 R5 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule